// File: doc/BRIEF.md
# Multi-Port Cell Receive Selector

This block sits on the cell-layer side of a byte-wide receive link that serves several PHY receive ports. Each port has its own enable output and its own cell-available, start-of-cell, data and parity inputs. The selector drives the enable of one port at a time and gathers the bytes of 53-byte cells into one local output stream. Each byte in that stream is tagged with the port it came from and with start, end, parity-error and short-cell flags.

The selector stays on a port until that port is at a cell boundary and shows no further cell ready. Only then does it let go of the port. The next port is picked round-robin among the ports that have a cell ready, beginning with the port after the one served last. All signals are timed to one free-running input clock. An asynchronous active-low reset returns the block to idle.

Top module: `cell_rx_selector`

## Requirements
- R1: At most one bit of `rx_en_o` is high in any cycle.
- R2: While a port is enabled, its enable stays high through the next edge unless, at that edge, the port is at a cell boundary (no byte of a cell pending), its start-of-cell is low and its cell-available is low. In that case the enable is low after the edge.
- R3: When no enable is high and at least one cell-available input is high at an edge, the enable of the first ready port after the last served port (index order, wrapping) is high after that edge. After reset the search begins at port 0.
- R4: A byte is taken only at an edge where its port's enable is high and either its start-of-cell is high or a cell is in progress. Bytes on disabled ports, and idle bytes on the enabled port, produce no output.
- R5: Each taken byte appears on the output one cycle later with `out_valid_o` high, its data unchanged, and `out_port_o` set to its port index. `out_sop_o` marks the first byte of a cell and `out_eop_o` marks byte 53. Byte order is preserved (5 header bytes, then 48 payload bytes).
- R6: Each byte must have odd parity over its 8 data bits plus its parity bit. On a byte that is not the last of its cell, `out_err_o` is high exactly when that byte fails the check.
- R7: On the byte-53 output, `out_err_o` is high if any byte of that cell failed the parity check.
- R8: A start-of-cell that arrives while a cell is in progress begins a new cell: its byte is output with `out_sop_o` and `out_runt_o` high, and byte counting restarts at 1 from that byte.
- R9: While `rst_ni` is low, all enables are low and `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_o | output | NUM_PORTS | Per-port receive enable |
| rx_clav_i | input | NUM_PORTS | Per-port cell-available |
| rx_soc_i | input | NUM_PORTS | Per-port start-of-cell pulse |
| rx_data_i | input | NUM_PORTS*8 | Per-port data byte, port p in bits [8p+7:8p] |
| rx_par_i | input | NUM_PORTS | Per-port odd parity bit |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_port_o | output | clog2(NUM_PORTS) | Source port of the output byte |
| out_sop_o | output | 1 | First byte of a cell |
| out_eop_o | output | 1 | Byte 53 of a cell |
| out_err_o | output | 1 | Parity error flag (cell-wide on byte 53) |
| out_runt_o | output | 1 | New cell cut the previous cell short |

## Verification
The assertions assume that an enabled PHY port sends a byte in every cycle while a cell is in progress. They also assume a PHY sends a start-of-cell only when its enable is high and it has a cell to send. The bench PHY model follows both rules on enabled ports. Disabled ports are driven with random data and stray start-of-cell pulses, to show that such input is ignored. The model starts a cell only when it holds a cell. It drops cell-available in the same cycle that its last cell starts, so the selector must stay on the port through that cell. It inserts idle gaps only at cell boundaries, and it cuts cells short only when it has another cell to send.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              soc;
    logic              bad;   // odd-parity violation
  } rx_byte_t;
endpackage

// File: rtl/rx_rr_arb.sv
module rx_rr_arb #(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] req_i,
  input  logic [IDX_W-1:0]     last_i,
  output logic                 gnt_vld_o,
  output logic [IDX_W-1:0]     gnt_idx_o
);
  always_comb begin
    int unsigned cand;
    gnt_vld_o = 1'b0;
    gnt_idx_o = last_i;
    // farthest offset first so the nearest ready port wins
    for (int off = NUM_PORTS; off >= 1; off--) begin
      cand = (int'(last_i) + off) % NUM_PORTS;
      if (req_i[cand]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/rx_port_mux.sv
module rx_port_mux
  import cell_rx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [IDX_W-1:0]            sel_i,
  input  logic [NUM_PORTS*BYTE_W-1:0] data_i,
  input  logic [NUM_PORTS-1:0]        soc_i,
  input  logic [NUM_PORTS-1:0]        par_i,
  output rx_byte_t                    byte_o
);
  logic [BYTE_W-1:0] lane [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
    assign lane[p] = data_i[p*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o.data = lane[sel_i];
    byte_o.soc  = soc_i[sel_i];
    byte_o.bad  = ~^{lane[sel_i], par_i[sel_i]};
  end
endmodule

// File: rtl/rx_cell_framer.sv
module rx_cell_framer
  import cell_rx_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int IDX_W      = 2,
  localparam int CNT_W = $clog2(CELL_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  rx_byte_t          byte_i,
  input  logic [IDX_W-1:0]  port_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic [IDX_W-1:0]  out_port_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_err_o,
  output logic              out_runt_o
);
  logic [CNT_W-1:0] cnt_q, idx;
  logic             err_acc_q, acc_nxt, accept, last;

  assign busy_o  = (cnt_q != '0);
  assign accept  = take_i & (byte_i.soc | busy_o);
  assign idx     = byte_i.soc ? '0 : cnt_q;
  assign last    = (idx == CNT_W'(CELL_BYTES-1));
  assign acc_nxt = (err_acc_q & ~byte_i.soc) | byte_i.bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      err_acc_q   <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_port_o  <= '0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      out_err_o   <= 1'b0;
      out_runt_o  <= 1'b0;
    end else begin
      out_valid_o <= accept;
      if (accept) begin
        cnt_q      <= last ? '0 : CNT_W'(idx + 1'b1);
        err_acc_q  <= acc_nxt;
        out_data_o <= byte_i.data;
        out_port_o <= port_i;
        out_sop_o  <= byte_i.soc;
        out_eop_o  <= last;
        out_err_o  <= last ? acc_nxt : byte_i.bad;
        out_runt_o <= byte_i.soc & busy_o;
      end
    end
  end

  assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(CELL_BYTES));
  assert_sop_not_eop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sop_o |-> !out_eop_o);
  assert_runt_on_sop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_runt_o |-> out_sop_o);
  assert_count_restarts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sop_o |-> cnt_q == CNT_W'(1) || CELL_BYTES == 1);
endmodule

// File: rtl/cell_rx_selector.sv
module cell_rx_selector
  import cell_rx_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int CELL_BYTES = 53,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  output logic [NUM_PORTS-1:0]        rx_en_o,
  input  logic [NUM_PORTS-1:0]        rx_clav_i,
  input  logic [NUM_PORTS-1:0]        rx_soc_i,
  input  logic [NUM_PORTS*BYTE_W-1:0] rx_data_i,
  input  logic [NUM_PORTS-1:0]        rx_par_i,
  output logic                        out_valid_o,
  output logic [BYTE_W-1:0]           out_data_o,
  output logic [IDX_W-1:0]            out_port_o,
  output logic                        out_sop_o,
  output logic                        out_eop_o,
  output logic                        out_err_o,
  output logic                        out_runt_o
);
  logic             active_q;
  logic [IDX_W-1:0] sel_q, gnt_idx;
  logic             gnt_vld, busy;
  rx_byte_t         cur;

  rx_rr_arb #(.NUM_PORTS(NUM_PORTS)) i_arb (
    .req_i     (rx_clav_i),
    .last_i    (sel_q),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx)
  );

  rx_port_mux #(.NUM_PORTS(NUM_PORTS)) i_mux (
    .sel_i  (sel_q),
    .data_i (rx_data_i),
    .soc_i  (rx_soc_i),
    .par_i  (rx_par_i),
    .byte_o (cur)
  );

  rx_cell_framer #(.CELL_BYTES(CELL_BYTES), .IDX_W(IDX_W)) i_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (active_q),
    .byte_i      (cur),
    .port_i      (sel_q),
    .busy_o      (busy),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_port_o  (out_port_o),
    .out_sop_o   (out_sop_o),
    .out_eop_o   (out_eop_o),
    .out_err_o   (out_err_o),
    .out_runt_o  (out_runt_o)
  );

  // sel_q keeps the last served port while idle; it seeds the round-robin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sel_q    <= IDX_W'(NUM_PORTS-1);
    end else if (!active_q) begin
      if (gnt_vld) begin
        active_q <= 1'b1;
        sel_q    <= gnt_idx;
      end
    end else if (!busy && !cur.soc && !rx_clav_i[sel_q]) begin
      active_q <= 1'b0;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_en
    assign rx_en_o[p] = active_q && (sel_q == IDX_W'(p));
  end

  assert_onehot_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_en_o));
  assert_hold_ready_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rx_en_o & rx_clav_i) |=> rx_en_o == $past(rx_en_o));
  assert_hold_mid_cell_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_en_o) && out_valid_o && !out_eop_o |=> rx_en_o == $past(rx_en_o));
  assert_grant_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|rx_en_o) |-> |($past(rx_clav_i) & rx_en_o));
  assert_take_when_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(|rx_en_o));
endmodule

// File: tb/test_cell_rx_selector.sv
module test_cell_rx_selector;
  localparam int N = 4;
  localparam int W = 8;
  localparam int CELL = 53;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_ni;
  logic [N-1:0]    rx_en_o, rx_clav_i, rx_soc_i, rx_par_i;
  logic [N*W-1:0]  rx_data_i;
  logic            out_valid_o, out_sop_o, out_eop_o, out_err_o, out_runt_o;
  logic [W-1:0]    out_data_o;
  logic [IW-1:0]   out_port_o;

  cell_rx_selector #(.NUM_PORTS(N), .CELL_BYTES(CELL)) i_cell_rx_selector (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_o(rx_en_o), .rx_clav_i(rx_clav_i),
    .rx_soc_i(rx_soc_i), .rx_data_i(rx_data_i), .rx_par_i(rx_par_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_port_o(out_port_o),
    .out_sop_o(out_sop_o), .out_eop_o(out_eop_o), .out_err_o(out_err_o),
    .out_runt_o(out_runt_o)
  );

  int n_chk = 0, n_bad = 0;
  int cells_left [N];
  int pos [N];
  logic cerr [N];
  int last_srv = N-1;
  logic [N-1:0] exp_en = '0;
  string en_tag = "R3";
  bit run = 0, rnd = 0, ended = 0;
  int abort_pos = -1;
  logic pv = 0, psop, peop, perr, prunt;
  logic [W-1:0] pdata;
  int pport;

  function automatic logic [N-1:0] rr_pick(input logic [N-1:0] req, input int last);
    logic [N-1:0] one = 1;
    for (int off = 1; off <= N; off++) begin
      int i;
      i = (last + off) % N;
      if (req[i]) return one << i;
    end
    return '0;
  endfunction

  task automatic fail(input string req, input string what, input longint act, input longint exp);
    n_bad++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) fail(req, what, act, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(negedge clk) if (run && !ended) begin
    logic [N-1:0] cur;
    int sel_pb;
    logic sel_soc;
    // enables from previous edge
    chk($countones(rx_en_o) <= 1, "R1", "enable one-hot", rx_en_o, exp_en);
    chk(rx_en_o === exp_en, en_tag, "enable", rx_en_o, exp_en);
    // output from previous edge
    chk(out_valid_o === pv, "R4", "out_valid", out_valid_o, pv);
    if (pv && out_valid_o) begin
      chk(out_data_o === pdata, "R5", "data", out_data_o, pdata);
      chk(out_port_o === IW'(pport), "R5", "port", out_port_o, pport);
      chk(out_sop_o === psop, "R5", "sop", out_sop_o, psop);
      chk(out_eop_o === peop, "R5", "eop", out_eop_o, peop);
      chk(out_err_o === perr, peop ? "R7" : "R6", "err", out_err_o, perr);
      chk(out_runt_o === prunt, "R8", "runt", out_runt_o, prunt);
    end
    // drive next byte on each port
    cur = rx_en_o;
    for (int p = 0; p < N; p++) if (cur[p]) last_srv = p;
    pv = 1'b0; sel_pb = 0; sel_soc = 1'b0;
    for (int p = 0; p < N; p++) begin
      logic [W-1:0] d;
      logic bad, soc;
      int pb;
      d = W'($urandom);
      bad = ($urandom % 20 == 0);
      soc = 1'b0;
      pb = pos[p];
      if (cur[p]) begin
        if (pb != 0 && cells_left[p] > 0 &&
            (pb == abort_pos || (rnd && $urandom % 500 == 0))) begin
          soc = 1'b1; cells_left[p]--; cerr[p] = bad; pos[p] = 1;
          pv = 1; psop = 1; peop = 0; perr = bad; prunt = 1;
        end else if (pb != 0) begin
          cerr[p] = cerr[p] | bad;
          peop = (pb == CELL-1);
          pv = 1; psop = 0; prunt = 0;
          perr = peop ? cerr[p] : bad;
          pos[p] = peop ? 0 : pb + 1;
        end else if (cells_left[p] > 0 && $urandom % 4 != 0) begin
          soc = 1'b1; cells_left[p]--; cerr[p] = bad; pos[p] = 1;
          pv = 1; psop = 1; peop = 0; perr = bad; prunt = 0;
        end else begin
          bad = $urandom % 2;
        end
        if (pv) begin pdata = d; pport = p; end
        sel_pb = pb; sel_soc = soc;
      end else begin
        soc = ($urandom % 8 == 0);
        bad = $urandom % 2;
      end
      rx_data_i[p*W +: W] = d;
      rx_soc_i[p] = soc;
      rx_par_i[p] = bad ? ^d : ~^d;
    end
    if (rnd && $urandom % 200 == 0) begin
      int q;
      q = $urandom % N;
      cells_left[q] += 1 + $urandom % 3;
    end
    for (int p = 0; p < N; p++) rx_clav_i[p] = (cells_left[p] > 0);
    if (cur == '0) begin
      exp_en = rr_pick(rx_clav_i, last_srv);
      en_tag = "R3";
    end else begin
      exp_en = (sel_pb == 0 && !sel_soc && !rx_clav_i[last_srv]) ? '0 : cur;
      en_tag = "R2";
    end
  end

  initial begin
    rst_ni = 1'b0;
    rx_clav_i = '0; rx_soc_i = '0; rx_par_i = '0; rx_data_i = '0;
    for (int p = 0; p < N; p++) begin pos[p] = 0; cerr[p] = 0; cells_left[p] = 0; end
    cells_left[0] = 2; cells_left[2] = 1; cells_left[3] = 1;
    repeat (3) @(negedge clk);
    chk(rx_en_o === '0, "R9", "enable in reset", rx_en_o, 0);
    chk(out_valid_o === 1'b0, "R9", "valid in reset", out_valid_o, 0);
    rst_ni = 1'b1;
    @(posedge clk);
    run = 1;
    abort_pos = 1;          // directed short cell on port 0
    repeat (300) @(negedge clk);
    abort_pos = -1;
    rnd = 1;
    repeat (20000) @(negedge clk);
    rnd = 0;
    for (int k = 0; k < 30000; k++) begin
      int busy;
      @(negedge clk);
      busy = 0;
      for (int p = 0; p < N; p++) busy += cells_left[p] + pos[p];
      if (busy == 0 && rx_en_o == '0) break;
    end
    repeat (5) @(negedge clk);
    ended = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ended = 1;
    fail("ALL", "watchdog expired", 0, 1);
    summary();
    $finish;
  end
endmodule